// File: doc/BRIEF.md
# Four-Approach Red/Green Signal Controller with Car Preemption

This block drives four one-way stop lights, named A to D, that show only red or green. It runs from a 60 Hz clock. Its seconds timebase and dwell timer are built in. When no car is detected, exactly one approach is green at a time. The green moves round the junction in the fixed clockwise order A, D, C, B and then back to A, and each approach holds the green for a dwell of X seconds (parameter, default 13).

Each approach has a car-presence sensor. The block registers each sensor and responds only to its rising edge. When a car arrives on a red approach, the current green stays on for floor(X/2) seconds. Then the old green and the requested approach swap in one cycle, and the requested approach holds green for X seconds. When a car arrives on the approach that is already green, that green is extended by X seconds, counted from detection. After either kind of preemption, rotation resumes at the approach clockwise after the one served.

Arrivals are assumed to be far enough apart that a new request never lands during a preemption. Reset is synchronous and active low.

Top module: `sig4_ctrl`

## Requirements
- R1: Each light output is 2 bits and is only ever 00 (green) or 01 (red). The code 1x never appears.
- R2: At every cycle out of reset, exactly one of the four lights is green.
- R3: With no sensor activity, green moves in the order A, D, C, B, A. Each approach is green for exactly DWELL_S*CLK_HZ cycles.
- R4: A sensor is sampled through two register stages, so a rise is acted on at the second clock edge after the input goes high (the detection edge). When the rising sensor belongs to a red approach, the previous green stays green for HALF*CLK_HZ cycles after the detection edge, where HALF = floor(DWELL_S/2). In that same cycle the previous green turns red and the requested approach turns green.
- R5: A preempted green lasts DWELL_S*CLK_HZ cycles. Green then passes to the next approach clockwise after the served one, and that approach gets a full dwell.
- R6: When the rising sensor belongs to the approach already green, that light stays green for DWELL_S*CLK_HZ cycles after the detection edge. Green then passes to the next approach clockwise, which gets a full dwell.
- R7: A sensor held high causes only one preemption. After the preemption ends, the rotation continues with normal dwells while the sensor stays high.
- R8: While rst_n is 0 at a clock edge, the block returns to A green with the other three red. A full dwell for A starts when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (CLK_HZ cycles per second) |
| rst_n | input | 1 | Synchronous reset, active low |
| sens_a | input | 1 | Car present on approach A |
| sens_b | input | 1 | Car present on approach B |
| sens_c | input | 1 | Car present on approach C |
| sens_d | input | 1 | Car present on approach D |
| lamp_a | output | 2 | Light A: 00 green, 01 red |
| lamp_b | output | 2 | Light B: 00 green, 01 red |
| lamp_c | output | 2 | Light C: 00 green, 01 red |
| lamp_d | output | 2 | Light D: 00 green, 01 red |

## Verification
The bench first runs directed cases:
- a quiet rotation, which exposes a wrong dwell length or a wrong rotation direction;
- a request on a red approach, which separates the delay and the swap cycle from the hold length and the resume point;
- a request on the green approach, which shows an extension apart from a fresh preemption;
- a sensor held high, which exposes a level-triggered design that fires again;
- a reset in mid-phase, which shows whether the dwell timer is cleared.

Random arrivals on random lanes, with random hold times, then land at arbitrary points in a dwell. The lights are compared every cycle with a bench timing model, which catches off-by-one errors in the timebase and restart.

// File: rtl/sig4_pkg.sv
package sig4_pkg;

    typedef logic [1:0] lamp_t;
    localparam lamp_t LAMP_GO   = 2'b00;
    localparam lamp_t LAMP_STOP = 2'b01;

    localparam int NUM_APP = 4;

    typedef enum logic [1:0] {
        APP_A = 2'd0,
        APP_B = 2'd1,
        APP_C = 2'd2,
        APP_D = 2'd3
    } app_t;

    typedef enum logic [1:0] {
        PH_ROTATE = 2'd0,
        PH_DELAY  = 2'd1,
        PH_HOLD   = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t ph;
        app_t   green;
        app_t   tgt;
    } ctl_t;

    // clockwise successor: A->D->C->B->A
    function automatic app_t cw_next(app_t a);
        return app_t'(a - 2'd1);
    endfunction

    // lowest-numbered requesting approach
    function automatic app_t pick_req(logic [NUM_APP-1:0] hit);
        app_t r = APP_A;
        for (int i = NUM_APP - 1; i >= 0; i--) begin
            if (hit[i]) r = app_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sig4_tick.sv
module sig4_tick #(
    parameter int CLK_HZ = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick
);
    localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [PW-1:0] PRE_MAX = PW'(CLK_HZ - 1);

    logic [PW-1:0] pre;

    assign sec_tick = (pre == PRE_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre <= '0;
        else if (sec_tick)     pre <= '0;
        else                   pre <= pre + 1'b1;
    end

    // R3
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre <= PRE_MAX);

endmodule

// File: rtl/sig4_sense.sv
module sig4_sense #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sens,
    output logic [LANES-1:0] hit
);
    logic [LANES-1:0] s1, s2;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1[i] <= 1'b0;
                s2[i] <= 1'b0;
            end else begin
                s1[i] <= sens[i];
                s2[i] <= s1[i];
            end
        end
        assign hit[i] = s1[i] & ~s2[i];
    end

    // R7
    hit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((hit & $past(hit)) == '0));

endmodule

// File: rtl/sig4_phase.sv
module sig4_phase
    import sig4_pkg::*;
#(
    parameter int DWELL_S = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sec_tick,
    input  logic [NUM_APP-1:0] hit,
    output logic               restart,
    output app_t               green
);
    localparam int HALF_S = DWELL_S / 2;
    localparam int SW = $clog2(DWELL_S + 1);
    localparam logic [SW-1:0] DW_L = SW'(DWELL_S);
    localparam logic [SW-1:0] HF_L = SW'(HALF_S);

    ctl_t          cur, nxt;
    logic [SW-1:0] secs, limit;
    logic          phase_end;
    app_t          req;

    assign limit     = (cur.ph == PH_DELAY) ? HF_L : DW_L;
    assign phase_end = sec_tick && (secs == limit - 1'b1);
    assign req       = pick_req(hit);
    assign green     = cur.green;

    always_comb begin
        nxt     = cur;
        restart = 1'b0;
        unique case (cur.ph)
            PH_ROTATE: begin
                if (hit != '0) begin
                    restart = 1'b1;
                    if (req == cur.green) begin
                        nxt.ph = PH_HOLD;
                    end else if (HALF_S == 0) begin
                        nxt.green = req;
                        nxt.ph    = PH_HOLD;
                    end else begin
                        nxt.tgt = req;
                        nxt.ph  = PH_DELAY;
                    end
                end else if (phase_end) begin
                    restart   = 1'b1;
                    nxt.green = cw_next(cur.green);
                end
            end
            PH_DELAY: begin
                if (phase_end) begin
                    restart   = 1'b1;
                    nxt.green = cur.tgt;
                    nxt.ph    = PH_HOLD;
                end
            end
            PH_HOLD: begin
                if (phase_end) begin
                    restart   = 1'b1;
                    nxt.green = cw_next(cur.green);
                    nxt.ph    = PH_ROTATE;
                end
            end
            default: begin
                restart = 1'b1;
                nxt.ph  = PH_ROTATE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.ph    <= PH_ROTATE;
            cur.green <= APP_A;
            cur.tgt   <= APP_A;
            secs      <= '0;
        end else begin
            cur <= nxt;
            if (restart)       secs <= '0;
            else if (sec_tick) secs <= secs + 1'b1;
        end
    end

    // R3
    secs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        secs < limit);

    // R3
    rot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.ph == PH_ROTATE && phase_end && hit == '0) |=>
            (green == cw_next($past(green))));

    // R4
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.ph == PH_DELAY && !phase_end) |=> $stable(green));

    // R4
    served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.ph == PH_DELAY && phase_end) |=>
            (green == $past(cur.tgt) && cur.ph == PH_HOLD));

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.ph == PH_HOLD && phase_end) |=>
            (green == cw_next($past(green)) && cur.ph == PH_ROTATE));

endmodule

// File: rtl/sig4_ctrl.sv
module sig4_ctrl
    import sig4_pkg::*;
#(
    parameter int CLK_HZ  = 60,
    parameter int DWELL_S = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sens_a,
    input  logic       sens_b,
    input  logic       sens_c,
    input  logic       sens_d,
    output logic [1:0] lamp_a,
    output logic [1:0] lamp_b,
    output logic [1:0] lamp_c,
    output logic [1:0] lamp_d
);
    logic [NUM_APP-1:0]   sens_v, hit;
    logic                 sec_tick, restart;
    app_t                 green;
    logic [2*NUM_APP-1:0] lamp_v;
    logic [NUM_APP-1:0]   go_mask;

    assign sens_v = {sens_d, sens_c, sens_b, sens_a};

    sig4_sense #(.LANES(NUM_APP)) u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .sens  (sens_v),
        .hit   (hit)
    );

    sig4_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sec_tick (sec_tick)
    );

    sig4_phase #(.DWELL_S(DWELL_S)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .hit      (hit),
        .restart  (restart),
        .green    (green)
    );

    for (genvar i = 0; i < NUM_APP; i++) begin : g_lamp
        assign lamp_v[2*i +: 2] = (green == app_t'(i)) ? LAMP_GO : LAMP_STOP;
        assign go_mask[i]       = (lamp_v[2*i +: 2] == LAMP_GO);
    end

    assign lamp_a = lamp_v[1:0];
    assign lamp_b = lamp_v[3:2];
    assign lamp_c = lamp_v[5:4];
    assign lamp_d = lamp_v[7:6];

    // R1
    lamp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lamp_a[1] && !lamp_b[1] && !lamp_c[1] && !lamp_d[1]);

    // R2
    one_green_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(go_mask) == 1);

endmodule

// File: tb/sim_sig4_ctrl.sv
module sim_sig4_ctrl;
    localparam int HZ = 60;
    localparam int XS = 13;
    localparam int DW = XS * HZ;
    localparam int HF = (XS / 2) * HZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sens = 4'b0;
    logic [1:0] lamp_a, lamp_b, lamp_c, lamp_d;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;

    sig4_ctrl #(.CLK_HZ(HZ), .DWELL_S(XS)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sens_a (sens[0]),
        .sens_b (sens[1]),
        .sens_c (sens[2]),
        .sens_d (sens[3]),
        .lamp_a (lamp_a),
        .lamp_b (lamp_b),
        .lamp_c (lamp_c),
        .lamp_d (lamp_d)
    );

    function automatic logic [7:0] exp_vec(int g);
        logic [7:0] v;
        for (int i = 0; i < 4; i++) v[2*i +: 2] = (i == g) ? 2'b00 : 2'b01;
        return v;
    endfunction

    function automatic int low_req(logic [3:0] h);
        for (int i = 0; i < 4; i++) if (h[i]) return i;
        return 0;
    endfunction

    wire [7:0] act = {lamp_d, lamp_c, lamp_b, lamp_a};

    task automatic chk(string req, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: lamps act=%b exp=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // timing model of the requirements (mode 0 rotate, 1 delay, 2 hold)
    logic [3:0] m1, m2, mh;
    int mg, mt, mode, mleft;
    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; mg = 0; mt = 0; mode = 0; mleft = DW;
        end else begin
            mh = m1 & ~m2;
            m2 = m1;
            m1 = sens;
            mleft = mleft - 1;
            if (mode == 0 && mh != 0) begin
                if (low_req(mh) == mg) begin
                    mode = 2; mleft = DW;
                end else begin
                    mode = 1; mt = low_req(mh); mleft = HF;
                end
            end else if (mleft == 0) begin
                if (mode == 1) begin
                    mg = mt; mode = 2;
                end else begin
                    mg = (mg + 3) % 4; mode = 0;
                end
                mleft = DW;
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) chk("R2/R3 model", exp_vec(mg));
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        rst_n = 1'b1;
        model_on = 1'b1;
        chk("R1 reset state A green", exp_vec(0));
        step(779); chk("R3 A dwell end", exp_vec(0));
        step(1);   chk("R3 A->D", exp_vec(3));
        // request on red C while D green
        sens[2] = 1'b1;
        step(HF + 1); chk("R4 old green held in delay", exp_vec(3));
        step(1);      chk("R4 swap to C", exp_vec(2));
        sens[2] = 1'b0;
        step(DW - 1); chk("R5 C held", exp_vec(2));
        step(1);      chk("R5 resume at B", exp_vec(1));
        // request on green B
        step(100);
        sens[1] = 1'b1;
        step(DW + 1); chk("R6 B extended", exp_vec(1));
        step(1);      chk("R6 B->A", exp_vec(0));
        // sensor still high: no second preemption
        step(DW - 1); chk("R7 A normal dwell", exp_vec(0));
        step(1);      chk("R7 A->D", exp_vec(3));
        sens[1] = 1'b0;
        // mid-phase reset
        step(200);
        rst_n = 1'b0;
        step(3);
        chk("R8 in reset A green", exp_vec(0));
        rst_n = 1'b1;
        step(DW - 1); chk("R8 full dwell after reset", exp_vec(0));
        step(1);      chk("R8 A->D", exp_vec(3));
        // random arrivals
        for (int k = 0; k < 20; k++) begin
            int lane, hold, gap;
            lane = int'($urandom % 4);
            hold = 1 + int'($urandom % 1200);
            gap  = 1300 + int'($urandom % 1500);
            sens[lane] = 1'b1;
            step(hold);
            sens[lane] = 1'b0;
            step(gap - hold);
        end
        step(DW * 2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule